// File: doc/BRIEF.md
# Branch History Configuration Register Unit

This unit holds the configuration and status state for a branch and control-transfer history buffer in a RISC-V style core. It has a machine control word, a virtual-supervisor control word, a depth register, a status register, and two single-bit state-enable gates, one machine-level and one hypervisor-level. The supervisor control word is not separate storage. It is a narrower view of the machine control word. The history entries themselves and the capture logic are outside this unit.

The core's CSR pipeline presents one access per cycle. Each access carries a register selector, a write value, a write mask, the current privilege level and a virtualization flag. Every access is a read-modify-write. One cycle later the unit answers with the value held before the write, or with an exception code.

The unit applies each register's legal-bit mask and clamps the depth. It keeps the history write pointer inside the buffer size. It decides whether the access is allowed, raising an illegal-instruction or a virtual-instruction exception when it is not.

Top module: `branch_hist_csr`

## Requirements
- R1: An accepted access sets the register to (old AND NOT m) OR (wdata AND m), where m is the write mask ANDed with the register's legal mask. The response comes exactly one cycle after the request (`rsp_valid_o` high), and `rsp_rdata_o` holds the visible value before the write.
- R2: Selector 0 is the machine control word, with legal mask 0x0000_FFFF_0000_7F0F. Selector 1 outside virtualization is the same storage seen through mask 0x0000_FFFF_0000_7F0D. Reads return the stored value ANDed with the mask of the view being accessed.
- R3: Selector 2, and selector 1 while virtualized, reach the separate virtual-supervisor control word, with mask 0x0000_FFFF_0000_7F05. The machine control word is left untouched.
- R4: Selector 3 is a 3-bit depth field at bits 2:0, encoding a buffer size of 16 shifted left by the field. A merged value above 4 is stored as 4.
- R5: A depth write whose mask covers any of bits 2:0 ANDs the status write pointer with (size-1) of the new depth. A depth write whose mask covers none of them changes nothing.
- R6: Selector 4 is the status register, with legal bits 31 and 7:0; bits 7:0 are the write pointer. After every status write the pointer is ANDed with (size-1) of the current depth.
- R7: Selector 0 raises illegal instruction (code 1) unless the machine-level extension input is set and the privilege is M (3).
- R8: Selectors 1 to 4 raise illegal instruction in any of these cases: neither extension input is set, the privilege is neither M nor S (1), or the privilege is S and the machine state-enable bit is clear.
- R9: After the R8 checks pass, a virtualized access to selectors 1 to 4 with the hypervisor state-enable bit clear raises virtual instruction (code 2).
- R10: A virtualized access to the depth register raises virtual instruction even when every other check passes.
- R11: Selector 5 (machine state-enable, bit 0) is allowed only at M. Selector 6 (hypervisor state-enable, bit 0) is allowed at M and at non-virtualized S; virtualized S raises code 2 and any other privilege raises code 1. Both bits are writable only while the supervisor-level extension input is set. Selector 7 always raises code 1.
- R12: When an exception is raised, no register changes and `rsp_rdata_o` is zero.
- R13: After reset every register reads zero and no response is pending.
- R14: At privilege M the virtualization flag is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Access request this cycle |
| req_sel_i | input | 3 | Register selector (0..7) |
| req_wdata_i | input | DATA_W | Write value |
| req_wmask_i | input | DATA_W | Bit write mask |
| req_priv_i | input | 2 | Privilege: 0 U, 1 S, 3 M |
| req_virt_i | input | 1 | Virtualized execution |
| ext_mach_i | input | 1 | Machine-level extension present |
| ext_sup_i | input | 1 | Supervisor-level extension present |
| rsp_valid_o | output | 1 | Response valid |
| rsp_rdata_o | output | DATA_W | Pre-write value, zero on exception |
| rsp_exc_o | output | 2 | 0 none, 1 illegal, 2 virtual instruction |

## Verification
The hardest case to reach is the depth shrink with a large write pointer. A pointer above 15 only exists when the depth has been raised earlier and the pointer written while the buffer was large. The stimulus therefore writes depth 7 (clamped to 4), writes a full pointer, and then shrinks the depth in steps to watch the pointer get truncated. The layered permission checks are reached by arming the two state-enable bits one at a time, first from M and then from non-virtualized S. Between these steps, virtualized supervisor accesses are issued. A long random run, checked against an independent model, then mixes the extension inputs, privileges and masks.

// File: rtl/bh_csr_pkg.sv
package bh_csr_pkg;

  typedef enum logic [2:0] {
    SEL_MCTL   = 3'd0,
    SEL_SCTL   = 3'd1,
    SEL_VCTL   = 3'd2,
    SEL_DEPTH  = 3'd3,
    SEL_STATUS = 3'd4,
    SEL_MSE    = 3'd5,
    SEL_HSE    = 3'd6,
    SEL_NONE   = 3'd7
  } sel_e;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_ILLEGAL = 2'd1,
    EXC_VIRT    = 2'd2
  } exc_e;

  typedef enum logic [2:0] {
    RT_MCTL_M,
    RT_MCTL_S,
    RT_VCTL,
    RT_DEPTH,
    RT_STATUS,
    RT_MSE,
    RT_HSE,
    RT_NONE
  } route_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

endpackage

// File: rtl/bh_access_gate.sv
module bh_access_gate
  import bh_csr_pkg::*;
(
  input  logic [2:0] sel_i,
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       ext_m_i,
  input  logic       ext_s_i,
  input  logic       mse_i,
  input  logic       hse_i,
  output exc_e       exc_o,
  output route_e     route_o
);

  logic virt_eff;
  exc_e sup_exc;

  // R14: virtualization has no meaning at machine level
  assign virt_eff = virt_i && (priv_i != PRIV_M);

  // R8 / R9: layered supervisor permission checks
  always_comb begin
    if (!ext_m_i && !ext_s_i)                 sup_exc = EXC_ILLEGAL;
    else if (priv_i != PRIV_M && priv_i != PRIV_S) sup_exc = EXC_ILLEGAL;
    else if (priv_i == PRIV_S && !mse_i)      sup_exc = EXC_ILLEGAL;
    else if (virt_eff && !hse_i)              sup_exc = EXC_VIRT;
    else                                      sup_exc = EXC_NONE;
  end

  always_comb begin
    exc_o   = EXC_ILLEGAL;
    route_o = RT_NONE;
    case (sel_i)
      SEL_MCTL: begin
        route_o = RT_MCTL_M;
        exc_o   = (ext_m_i && priv_i == PRIV_M) ? EXC_NONE : EXC_ILLEGAL;
      end
      SEL_SCTL: begin
        route_o = virt_eff ? RT_VCTL : RT_MCTL_S;
        exc_o   = sup_exc;
      end
      SEL_VCTL: begin
        route_o = RT_VCTL;
        exc_o   = sup_exc;
      end
      SEL_DEPTH: begin
        route_o = RT_DEPTH;
        exc_o   = (sup_exc == EXC_NONE && virt_eff) ? EXC_VIRT : sup_exc;
      end
      SEL_STATUS: begin
        route_o = RT_STATUS;
        exc_o   = sup_exc;
      end
      SEL_MSE: begin
        route_o = RT_MSE;
        exc_o   = (priv_i == PRIV_M) ? EXC_NONE : EXC_ILLEGAL;
      end
      SEL_HSE: begin
        route_o = RT_HSE;
        if (priv_i == PRIV_M)      exc_o = EXC_NONE;
        else if (priv_i == PRIV_S) exc_o = virt_eff ? EXC_VIRT : EXC_NONE;
        else                       exc_o = EXC_ILLEGAL;
      end
      default: begin
        route_o = RT_NONE;
        exc_o   = EXC_ILLEGAL;
      end
    endcase
  end

endmodule

// File: rtl/bh_reg_store.sv
module bh_reg_store
  import bh_csr_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned DEP_W     = 3,
  parameter int unsigned DEPTH_MAX = 4,
  parameter int unsigned PTR_W     = 8,
  parameter int unsigned STAT_W    = 32,
  parameter logic [DATA_W-1:0] M_MASK = 64'h0000_FFFF_0000_7F0F,
  parameter logic [DATA_W-1:0] S_MASK = 64'h0000_FFFF_0000_7F0D,
  parameter logic [DATA_W-1:0] V_MASK = 64'h0000_FFFF_0000_7F05
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  route_e            route_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] wmask_i,
  input  logic              ext_s_i,
  output logic [DATA_W-1:0] rd_old_o,
  output logic [DATA_W-1:0] mctl_q,
  output logic [DATA_W-1:0] vctl_q,
  output logic [DEP_W-1:0]  depth_q,
  output logic [STAT_W-1:0] status_q,
  output logic              mse_q,
  output logic              hse_q,
  output logic              depth_touch_o
);

  localparam logic [STAT_W-1:0] STAT_MASK =
    (STAT_W'(1) << (STAT_W - 1)) | STAT_W'((64'd1 << PTR_W) - 64'd1);
  localparam logic [DEP_W-1:0] DMAX = DEP_W'(DEPTH_MAX);

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                               input logic [DATA_W-1:0] new_v,
                                               input logic [DATA_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  // size - 1 for a depth code: (16 << d) - 1
  function automatic logic [PTR_W-1:0] ptr_limit(input logic [DEP_W-1:0] d);
    return PTR_W'((32'd16 << d) - 32'd1);
  endfunction

  function automatic logic [DEP_W-1:0] clamp_depth(input logic [DEP_W-1:0] d);
    return (d > DMAX) ? DMAX : d;
  endfunction

  logic [DATA_W-1:0] mctl_nx, vctl_nx;
  logic [DEP_W-1:0]  depth_nx, dmask, dmerged;
  logic [STAT_W-1:0] status_nx, smask;
  logic              mse_nx, hse_nx;

  assign dmask   = wmask_i[DEP_W-1:0];
  assign dmerged = (depth_q & ~dmask) | (wdata_i[DEP_W-1:0] & dmask);
  assign smask   = wmask_i[STAT_W-1:0] & STAT_MASK;

  always_comb begin
    case (route_i)
      RT_MCTL_M: rd_old_o = mctl_q & M_MASK;
      RT_MCTL_S: rd_old_o = mctl_q & S_MASK;
      RT_VCTL:   rd_old_o = vctl_q & V_MASK;
      RT_DEPTH:  rd_old_o = {{(DATA_W-DEP_W){1'b0}}, depth_q};
      RT_STATUS: rd_old_o = {{(DATA_W-STAT_W){1'b0}}, status_q};
      RT_MSE:    rd_old_o = {{(DATA_W-1){1'b0}}, mse_q};
      RT_HSE:    rd_old_o = {{(DATA_W-1){1'b0}}, hse_q};
      default:   rd_old_o = '0;
    endcase
  end

  always_comb begin
    mctl_nx       = mctl_q;
    vctl_nx       = vctl_q;
    depth_nx      = depth_q;
    status_nx     = status_q;
    mse_nx        = mse_q;
    hse_nx        = hse_q;
    depth_touch_o = 1'b0;
    if (commit_i) begin
      case (route_i)
        RT_MCTL_M: mctl_nx = merge(mctl_q, wdata_i, wmask_i & M_MASK);
        RT_MCTL_S: mctl_nx = merge(mctl_q, wdata_i, wmask_i & S_MASK);
        RT_VCTL:   vctl_nx = merge(vctl_q, wdata_i, wmask_i & V_MASK);
        RT_DEPTH: begin
          if (|dmask) begin
            depth_touch_o          = 1'b1;
            depth_nx               = clamp_depth(dmerged);
            status_nx[PTR_W-1:0]   = status_q[PTR_W-1:0] & ptr_limit(clamp_depth(dmerged));
          end
        end
        RT_STATUS: begin
          status_nx            = (status_q & ~smask) | (wdata_i[STAT_W-1:0] & smask);
          status_nx[PTR_W-1:0] = status_nx[PTR_W-1:0] & ptr_limit(depth_q);
        end
        RT_MSE: if (ext_s_i && wmask_i[0]) mse_nx = wdata_i[0];
        RT_HSE: if (ext_s_i && wmask_i[0]) hse_nx = wdata_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mctl_q   <= '0;
      vctl_q   <= '0;
      depth_q  <= '0;
      status_q <= '0;
      mse_q    <= 1'b0;
      hse_q    <= 1'b0;
    end else begin
      mctl_q   <= mctl_nx;
      vctl_q   <= vctl_nx;
      depth_q  <= depth_nx;
      status_q <= status_nx;
      mse_q    <= mse_nx;
      hse_q    <= hse_nx;
    end
  end

endmodule

// File: rtl/branch_hist_csr.sv
module branch_hist_csr
  import bh_csr_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned DEP_W     = 3,
  parameter int unsigned DEPTH_MAX = 4,
  parameter int unsigned STAT_W    = 32,
  parameter logic [DATA_W-1:0] M_MASK = 64'h0000_FFFF_0000_7F0F,
  parameter logic [DATA_W-1:0] S_MASK = 64'h0000_FFFF_0000_7F0D,
  parameter logic [DATA_W-1:0] V_MASK = 64'h0000_FFFF_0000_7F05
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_sel_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] req_wmask_i,
  input  logic [1:0]        req_priv_i,
  input  logic              req_virt_i,
  input  logic              ext_mach_i,
  input  logic              ext_sup_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [1:0]        rsp_exc_o
);

  localparam int unsigned PTR_W = 4 + DEPTH_MAX;

  exc_e              gate_exc;
  route_e            gate_route;
  logic              commit;
  logic              depth_touch;
  logic [DATA_W-1:0] rd_old;
  logic [DATA_W-1:0] mctl_q, vctl_q;
  logic [DEP_W-1:0]  depth_q;
  logic [STAT_W-1:0] status_q;
  logic              mse_q, hse_q;

  assign commit = req_valid_i && (gate_exc == EXC_NONE);

  bh_access_gate u_gate (
    .sel_i   (req_sel_i),
    .priv_i  (req_priv_i),
    .virt_i  (req_virt_i),
    .ext_m_i (ext_mach_i),
    .ext_s_i (ext_sup_i),
    .mse_i   (mse_q),
    .hse_i   (hse_q),
    .exc_o   (gate_exc),
    .route_o (gate_route)
  );

  bh_reg_store #(
    .DATA_W(DATA_W), .DEP_W(DEP_W), .DEPTH_MAX(DEPTH_MAX), .PTR_W(PTR_W),
    .STAT_W(STAT_W), .M_MASK(M_MASK), .S_MASK(S_MASK), .V_MASK(V_MASK)
  ) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .commit_i      (commit),
    .route_i       (gate_route),
    .wdata_i       (req_wdata_i),
    .wmask_i       (req_wmask_i),
    .ext_s_i       (ext_sup_i),
    .rd_old_o      (rd_old),
    .mctl_q        (mctl_q),
    .vctl_q        (vctl_q),
    .depth_q       (depth_q),
    .status_q      (status_q),
    .mse_q         (mse_q),
    .hse_q         (hse_q),
    .depth_touch_o (depth_touch)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_exc_o   <= EXC_NONE;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= (req_valid_i && gate_exc == EXC_NONE) ? rd_old : '0;
      rsp_exc_o   <= req_valid_i ? gate_exc : EXC_NONE;
    end
  end

endmodule

// File: rtl/bh_csr_checker.sv
module bh_csr_checker #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned DEP_W     = 3,
  parameter int unsigned DEPTH_MAX = 4,
  parameter int unsigned PTR_W     = 8,
  parameter int unsigned STAT_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_sel,
  input logic [1:0]        req_priv,
  input logic              req_virt,
  input logic              ext_m,
  input logic              ext_s,
  input logic [1:0]        gate_exc,
  input logic              depth_touch,
  input logic              rsp_valid,
  input logic [1:0]        rsp_exc,
  input logic [DATA_W-1:0] mctl_q,
  input logic [DATA_W-1:0] vctl_q,
  input logic [DEP_W-1:0]  depth_q,
  input logic [STAT_W-1:0] status_q,
  input logic              mse_q,
  input logic              hse_q
);

  // R1: response one cycle after each request
  a_r1_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R4: stored depth never above the maximum
  a_r4_depth_capped: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEP_W'(DEPTH_MAX));

  // R5 / R6: write pointer always inside the current buffer size
  a_r6_wrptr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    32'(status_q[PTR_W-1:0]) < (32'd16 << depth_q));

  // R5: touching the depth leaves a pointer no larger than before
  a_r5_shrink_only: assert property (@(posedge clk) disable iff (!rst_n)
    depth_touch |=> status_q[PTR_W-1:0] <= $past(status_q[PTR_W-1:0]));

  // R7: machine control word below M is illegal
  a_r7_mctl_priv: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_sel == 3'd0 && (req_priv != 2'd3 || !ext_m) |=> rsp_exc == 2'd1);

  // R10: virtualized depth access faults when all else passes
  a_r10_depth_virt: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_sel == 3'd3 && req_priv == 2'd1 && req_virt &&
    (ext_m || ext_s) && mse_q && hse_q |=> rsp_exc == 2'd2);

  // R11: enable bits locked without the supervisor-level extension
  a_r11_enable_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_s |=> $stable(mse_q) && $stable(hse_q));

  // R12: no state change on a faulting access
  a_r12_exc_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && gate_exc != 2'd0 |=> $stable(mctl_q) && $stable(vctl_q) &&
    $stable(depth_q) && $stable(status_q) && $stable(mse_q) && $stable(hse_q));

endmodule

bind branch_hist_csr bh_csr_checker #(
  .DATA_W(DATA_W), .DEP_W(DEP_W), .DEPTH_MAX(DEPTH_MAX), .PTR_W(PTR_W), .STAT_W(STAT_W)
) u_chk (
  .clk         (clk_i),
  .rst_n       (rst_ni),
  .req_valid   (req_valid_i),
  .req_sel     (req_sel_i),
  .req_priv    (req_priv_i),
  .req_virt    (req_virt_i),
  .ext_m       (ext_mach_i),
  .ext_s       (ext_sup_i),
  .gate_exc    (gate_exc),
  .depth_touch (depth_touch),
  .rsp_valid   (rsp_valid_o),
  .rsp_exc     (rsp_exc_o),
  .mctl_q      (mctl_q),
  .vctl_q      (vctl_q),
  .depth_q     (depth_q),
  .status_q    (status_q),
  .mse_q       (mse_q),
  .hse_q       (hse_q)
);

// File: tb/sim_branch_hist_csr.sv
`timescale 1ns/1ps
module sim_branch_hist_csr;

  localparam logic [63:0] MM = 64'h0000_FFFF_0000_7F0F;
  localparam logic [63:0] SM = 64'h0000_FFFF_0000_7F0D;
  localparam logic [63:0] VM = 64'h0000_FFFF_0000_7F05;
  localparam logic [31:0] STM = 32'h8000_00FF;
  localparam logic [63:0] ALL = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_sel = '0;
  logic [63:0] req_wdata = '0, req_wmask = '0;
  logic [1:0]  req_priv = 2'd3;
  logic        req_virt = 1'b0;
  logic        em = 1'b1, es = 1'b1;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic [1:0]  rsp_exc;

  int checks = 0, fails = 0;

  // independent model state
  logic [63:0] m_ctl = '0, v_ctl = '0;
  int          m_dep = 0;
  logic [31:0] m_st = '0;
  logic        m_mse = 1'b0, m_hse = 1'b0;

  logic [63:0] q_rd[$];
  logic [1:0]  q_ex[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  branch_hist_csr u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_sel_i(req_sel),
    .req_wdata_i(req_wdata), .req_wmask_i(req_wmask), .req_priv_i(req_priv),
    .req_virt_i(req_virt), .ext_mach_i(em), .ext_sup_i(es),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_exc_o(rsp_exc)
  );

  function automatic logic [1:0] sup_rule(input logic [1:0] p, input bit ve);
    if (!em && !es) return 2'd1;
    if (p != 2'd3 && p != 2'd1) return 2'd1;
    if (p == 2'd1 && !m_mse) return 2'd1;
    if (ve && !m_hse) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [7:0] wrap_ptr(input logic [7:0] ptr, input int d);
    return 8'(int'(ptr) % (16 << d));
  endfunction

  task automatic acc(input logic [2:0] s, input logic [63:0] wd, input logic [63:0] wm,
                     input logic [1:0] p, input bit vt, input string tag);
    bit ve;
    logic [1:0] ex;
    logic [63:0] rd, k;
    int nd;
    ve = vt && (p != 2'd3);
    ex = 2'd0;
    rd = '0;
    case (s)
      3'd0: begin
        ex = (em && p == 2'd3) ? 2'd0 : 2'd1;
        rd = m_ctl & MM;
        if (ex == 0) begin k = wm & MM; m_ctl = (m_ctl & ~k) | (wd & k); end
      end
      3'd1, 3'd2: begin
        ex = sup_rule(p, ve);
        if (s == 3'd2 || ve) begin
          rd = v_ctl & VM;
          if (ex == 0) begin k = wm & VM; v_ctl = (v_ctl & ~k) | (wd & k); end
        end else begin
          rd = m_ctl & SM;
          if (ex == 0) begin k = wm & SM; m_ctl = (m_ctl & ~k) | (wd & k); end
        end
      end
      3'd3: begin
        ex = sup_rule(p, ve);
        if (ex == 0 && ve) ex = 2'd2;
        rd = 64'(m_dep);
        if (ex == 0 && wm[2:0] != 3'b0) begin
          nd = int'((3'(m_dep) & ~wm[2:0]) | (wd[2:0] & wm[2:0]));
          if (nd > 4) nd = 4;
          m_dep = nd;
          m_st[7:0] = wrap_ptr(m_st[7:0], m_dep);
        end
      end
      3'd4: begin
        ex = sup_rule(p, ve);
        rd = {32'b0, m_st};
        if (ex == 0) begin
          m_st = (m_st & ~(wm[31:0] & STM)) | (wd[31:0] & wm[31:0] & STM);
          m_st[7:0] = wrap_ptr(m_st[7:0], m_dep);
        end
      end
      3'd5: begin
        ex = (p == 2'd3) ? 2'd0 : 2'd1;
        rd = {63'b0, m_mse};
        if (ex == 0 && es && wm[0]) m_mse = wd[0];
      end
      3'd6: begin
        if (p == 2'd3) ex = 2'd0;
        else if (p == 2'd1) ex = ve ? 2'd2 : 2'd0;
        else ex = 2'd1;
        rd = {63'b0, m_hse};
        if (ex == 0 && es && wm[0]) m_hse = wd[0];
      end
      default: ex = 2'd1;
    endcase
    if (ex != 0) rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_sel = s; req_wdata = wd; req_wmask = wm;
    req_priv = p; req_virt = vt;
    q_rd.push_back(rd); q_ex.push_back(ex); q_tag.push_back(tag);
  endtask

  task automatic rd(input logic [2:0] s, input string tag);
    acc(s, '0, '0, 2'd3, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q_rd.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected response rdata=%h exc=%0d expected none", rsp_rdata, rsp_exc);
      end else begin
        logic [63:0] e_rd;
        logic [1:0]  e_ex;
        string       t;
        e_rd = q_rd.pop_front(); e_ex = q_ex.pop_front(); t = q_tag.pop_front();
        if (rsp_rdata !== e_rd || rsp_exc !== e_ex) begin
          fails++;
          $display("FAIL %s rdata=%h exc=%0d expected rdata=%h exc=%0d",
                   t, rsp_rdata, rsp_exc, e_rd, e_ex);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_exc !== 2'd0 || rsp_rdata !== '0) begin
      fails++;
      $display("FAIL R13 reset outputs valid=%b exc=%0d rdata=%h expected 0", rsp_valid, rsp_exc, rsp_rdata);
    end
    // R13: every register reads zero after reset
    for (int s = 0; s < 7; s++) rd(3'(s), "R13 reset value");

    // R1 / R2: machine control word
    acc(3'd0, ALL, ALL, 2'd3, 1'b0, "R1 full write old value");
    rd(3'd0, "R2 machine mask readback");
    acc(3'd0, '0, 64'h0F, 2'd3, 1'b0, "R1 partial mask write");
    rd(3'd0, "R1 partial mask result");
    acc(3'd0, ALL, ALL, 2'd3, 1'b0, "R1 refill");

    // R8 / R11: supervisor blocked until machine enable set
    acc(3'd1, '0, '0, 2'd1, 1'b0, "R8 S without machine enable");
    acc(3'd5, 64'h1, 64'h1, 2'd1, 1'b0, "R11 machine enable from S");
    acc(3'd5, 64'h1, 64'h1, 2'd3, 1'b0, "R11 machine enable from M");
    acc(3'd1, '0, ALL, 2'd1, 1'b0, "R2 supervisor view write");
    rd(3'd0, "R2 machine-only bit kept");

    // R9 / R3: virtualization
    acc(3'd1, '0, '0, 2'd1, 1'b1, "R9 virt without hyp enable");
    acc(3'd6, 64'h1, 64'h1, 2'd1, 1'b0, "R11 hyp enable from S");
    acc(3'd6, '0, '0, 2'd1, 1'b1, "R11 hyp enable from virt S");
    acc(3'd1, ALL, ALL, 2'd1, 1'b1, "R3 virt redirect write");
    rd(3'd2, "R3 virtual copy mask");
    rd(3'd0, "R3 machine word untouched");
    acc(3'd2, 64'h5, 64'h7, 2'd1, 1'b0, "R3 direct virtual copy");
    acc(3'd1, '0, '0, 2'd1, 1'b1, "R3 virtual readback");

    // R4 / R5 / R6: depth and pointer
    acc(3'd3, 64'h7, ALL, 2'd3, 1'b0, "R4 depth write above max");
    rd(3'd3, "R4 depth clamped to 4");
    acc(3'd4, ALL, ALL, 2'd3, 1'b0, "R6 status full write");
    rd(3'd4, "R6 status at depth 4");
    acc(3'd3, 64'h1, 64'h7, 2'd1, 1'b0, "R5 depth shrink to 1");
    rd(3'd4, "R5 pointer truncated to 31");
    acc(3'd3, 64'h0, 64'h8, 2'd3, 1'b0, "R5 mask misses depth bits");
    rd(3'd3, "R5 depth unchanged");
    rd(3'd4, "R5 status unchanged");
    acc(3'd3, 64'h4, 64'h7, 2'd3, 1'b0, "R5 depth grow");
    acc(3'd4, 64'h0000_00C3, 64'hFF, 2'd3, 1'b0, "R6 pointer 0xC3 at depth 4");
    acc(3'd3, 64'h0, 64'h7, 2'd3, 1'b0, "R5 depth to 0");
    rd(3'd4, "R5 pointer cut to 4 bits");
    acc(3'd4, 64'h0000_00FE, 64'hFF, 2'd3, 1'b0, "R6 status write re-mask at depth 0");
    rd(3'd4, "R6 pointer masked by current depth");

    // R10: virtualized depth
    acc(3'd3, 64'h2, ALL, 2'd1, 1'b1, "R10 depth while virtualized");
    rd(3'd3, "R10 depth unchanged");
    acc(3'd3, 64'h2, ALL, 2'd1, 1'b0, "R10 depth non-virtual S ok");

    // R12: faulting write leaves state
    acc(3'd0, '0, ALL, 2'd0, 1'b0, "R12 U write machine word");
    acc(3'd4, '0, ALL, 2'd0, 1'b0, "R8 U write status");
    rd(3'd0, "R12 machine word unchanged");
    rd(3'd4, "R12 status unchanged");
    acc(3'd7, ALL, ALL, 2'd3, 1'b0, "R11 selector 7 illegal");

    // R14: virt flag ignored at M
    acc(3'd1, 64'h0, 64'h100, 2'd3, 1'b1, "R14 M virt goes to machine word");
    rd(3'd0, "R14 machine word bit8 cleared");
    acc(3'd3, 64'h3, 64'h7, 2'd3, 1'b1, "R14 M virt depth allowed");

    // R7 / R8 / R11: extension inputs
    idle(1);
    em = 1'b0;
    acc(3'd0, '0, '0, 2'd3, 1'b0, "R7 machine ext absent");
    acc(3'd1, '0, '0, 2'd1, 1'b0, "R8 supervisor ext only");
    idle(1);
    es = 1'b0;
    acc(3'd4, '0, '0, 2'd3, 1'b0, "R8 no extension");
    idle(1);
    em = 1'b1;
    acc(3'd5, 64'h0, 64'h1, 2'd3, 1'b0, "R11 enable write ignored");
    rd(3'd5, "R11 enable still set");
    acc(3'd6, 64'h0, 64'h1, 2'd3, 1'b0, "R11 hyp write ignored");
    rd(3'd6, "R11 hyp enable still set");
    idle(1);
    es = 1'b1;

    // mixed random run against the model
    for (int i = 0; i < 400; i++) begin
      logic [1:0] p;
      logic [63:0] wm;
      if (i % 50 == 0) begin
        idle(0);
        em = ($urandom % 4) != 0;
        es = ($urandom % 4) != 0;
      end
      case ($urandom % 3) 0: p = 2'd0; 1: p = 2'd1; default: p = 2'd3; endcase
      wm = ($urandom % 2) ? ALL : {$urandom, $urandom};
      acc(3'($urandom), {$urandom, $urandom}, wm, p, 1'($urandom), "R1 random mix");
    end
    idle(4);
    if (q_rd.size() != 0) begin
      fails++;
      $display("FAIL R1 missing responses actual=%0d expected=0", q_rd.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule